// File: doc/BRIEF.md
# Coherence-Aware LRU Victim Selector

This block tracks access recency for every way of every set in a set-associative shared inclusive cache. When the cache needs room in a set, it asks the block for a victim way. The block ranks the candidates by coherence status before recency. A way that no other cache shares and that no other cache owns is evicted ahead of one that is shared or owned, so fewer evictions need recalls or invalidations. Recency only decides between ways of equal status.

Each access strobe carries a set index and a way. The touched way becomes the most recent way of its set. A victim request carries a set index and three per-way vectors: line valid, shared and owned. One cycle later the block returns the chosen way with a valid flag. Tags, coherence state storage and the eviction datapath sit outside the block. The cache controller supplies the status bits with every request.

Recency is held as one age counter of log2(ways) bits per way. Age 0 is the most recent way and age N-1 is the least recent. Within a set the ages always form a permutation of 0..N-1.

Top module: `lru_victim_sel`

## Requirements
- R1: After reset, `vic_valid_o` is 0. Every set holds way w at age w, so a request with all ways valid and no status bits set returns way NUM_WAYS-1.
- R2: `vic_valid_o` is 1 in the cycle after a cycle with `vic_req_i` high, and 0 in the cycle after a cycle with `vic_req_i` low. `vic_way_o` is sampled in that same cycle.
- R3: An access makes the touched way the most recent in its set. The relative order of the other ways is kept. When all ways are valid and of equal class, the victim is the way accessed longest ago.
- R4: The class of way w is `vic_shared_i[w] | vic_owned_i[w]`. Class 0 means neither shared nor owned; class 1 means shared or owned. When all ways are valid and at least one has class 0, the victim has class 0, whatever the recency.
- R5: Among valid ways of the lowest class present, the victim is the least recently accessed one.
- R6: If any bit of `vic_line_valid_i` is 0, the victim is the lowest-numbered way whose valid bit is 0. Recency and class are ignored in that case.
- R7: If an access and a victim request hit the same set in the same cycle, the access is applied first. The victim is chosen from the updated recency.
- R8: An access changes recency only in its own set. Victim choices in other sets are unaffected.
- R9: When every valid way has class 1, the choice falls back to plain least-recent order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_set_i | input | SET_W | Set index of the access |
| acc_way_i | input | WAY_W | Way touched by the access |
| vic_req_i | input | 1 | Victim request strobe |
| vic_set_i | input | SET_W | Set index of the victim request |
| vic_line_valid_i | input | NUM_WAYS | Per-way line valid bits |
| vic_shared_i | input | NUM_WAYS | Per-way shared status |
| vic_owned_i | input | NUM_WAYS | Per-way owned status |
| vic_valid_o | output | 1 | Victim result valid, one cycle after request |
| vic_way_o | output | WAY_W | Selected victim way |

## Verification
A corrupted age counter breaks the permutation for its set. The first victim request to that set whose status ties two ways then returns a way that is not the least recent, one cycle after the request. A wrong update rule for the ages that younger ways carry also shows up late. The error only appears once a later request in that set falls back on recency, often several accesses after the faulty update. For that reason the sweep runs all 256 shared/owned combinations on every set after a varied access history. A forwarding fault in the same-set collision case shows up at once: the victim is the way that was just touched.

// File: rtl/lru_victim_pkg.sv
package lru_victim_pkg;
  typedef enum logic {
    CLS_PRIVATE  = 1'b0,
    CLS_COHERENT = 1'b1
  } vic_class_e;

  function automatic vic_class_e way_class(input logic shared, input logic owned);
    return (shared | owned) ? CLS_COHERENT : CLS_PRIVATE;
  endfunction
endpackage

// File: rtl/lru_age_update.sv
module lru_age_update #(
  parameter int NUM_WAYS = 4,
  localparam int AGE_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0][AGE_W-1:0] ages_i,
  input  logic [AGE_W-1:0]               way_i,
  output logic [NUM_WAYS-1:0][AGE_W-1:0] ages_o
);
  logic [AGE_W-1:0] touched_age;
  assign touched_age = ages_i[way_i];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    always_comb begin
      if (way_i == AGE_W'(w))            ages_o[w] = '0;
      else if (ages_i[w] < touched_age)  ages_o[w] = ages_i[w] + AGE_W'(1);
      else                               ages_o[w] = ages_i[w];
    end
  end
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick
  import lru_victim_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int AGE_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0][AGE_W-1:0] ages_i,
  input  logic [NUM_WAYS-1:0]            line_valid_i,
  input  logic [NUM_WAYS-1:0]            shared_i,
  input  logic [NUM_WAYS-1:0]            owned_i,
  output logic [AGE_W-1:0]               way_o
);
  logic [NUM_WAYS-1:0][AGE_W:0] key;
  logic             inv_found;
  logic [AGE_W-1:0] inv_way;
  logic [AGE_W-1:0] best_way;
  logic [AGE_W:0]   best_key;

  // higher key wins: private class first, then oldest age
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_key
    vic_class_e cls;
    assign cls    = way_class(shared_i[w], owned_i[w]);
    assign key[w] = {cls == CLS_PRIVATE, ages_i[w]};
  end

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!line_valid_i[w]) begin
        inv_found = 1'b1;
        inv_way   = AGE_W'(w);
      end
    end
  end

  always_comb begin
    best_way = '0;
    best_key = key[0];
    for (int w = 1; w < NUM_WAYS; w++) begin
      if (key[w] > best_key) begin
        best_key = key[w];
        best_way = AGE_W'(w);
      end
    end
  end

  assign way_o = inv_found ? inv_way : best_way;
endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_valid_i,
  input  logic [SET_W-1:0]    acc_set_i,
  input  logic [WAY_W-1:0]    acc_way_i,
  input  logic                vic_req_i,
  input  logic [SET_W-1:0]    vic_set_i,
  input  logic [NUM_WAYS-1:0] vic_line_valid_i,
  input  logic [NUM_WAYS-1:0] vic_shared_i,
  input  logic [NUM_WAYS-1:0] vic_owned_i,
  output logic                vic_valid_o,
  output logic [WAY_W-1:0]    vic_way_o
);
  logic [NUM_WAYS-1:0][WAY_W-1:0] age_q [NUM_SETS];
  logic [NUM_WAYS-1:0][WAY_W-1:0] acc_cur, acc_upd, vic_ages;
  logic [WAY_W-1:0]               pick_way;
  logic                           same_set;

  assign acc_cur  = age_q[acc_set_i];
  assign same_set = acc_valid_i && (acc_set_i == vic_set_i);
  // access wins over a same-cycle request to the same set
  assign vic_ages = same_set ? acc_upd : age_q[vic_set_i];

  lru_age_update #(.NUM_WAYS(NUM_WAYS)) u_update (
    .ages_i (acc_cur),
    .way_i  (acc_way_i),
    .ages_o (acc_upd)
  );

  lru_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .ages_i       (vic_ages),
    .line_valid_i (vic_line_valid_i),
    .shared_i     (vic_shared_i),
    .owned_i      (vic_owned_i),
    .way_o        (pick_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (acc_valid_i) begin
      age_q[acc_set_i] <= acc_upd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vic_valid_o <= 1'b0;
      vic_way_o   <= '0;
    end else begin
      vic_valid_o <= vic_req_i;
      if (vic_req_i) vic_way_o <= pick_way;
    end
  end
endmodule

// File: rtl/lru_victim_sel_chk.sv
module lru_victim_sel_chk #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                acc_valid_i,
  input logic [SET_W-1:0]    acc_set_i,
  input logic [WAY_W-1:0]    acc_way_i,
  input logic                vic_req_i,
  input logic [SET_W-1:0]    vic_set_i,
  input logic [NUM_WAYS-1:0] vic_line_valid_i,
  input logic [NUM_WAYS-1:0] vic_shared_i,
  input logic [NUM_WAYS-1:0] vic_owned_i,
  input logic                vic_valid_o,
  input logic [WAY_W-1:0]    vic_way_o
);
  logic [NUM_WAYS-1:0] lv_q, cls_q;
  logic                lower_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lv_q  <= '1;
      cls_q <= '0;
    end else if (vic_req_i) begin
      lv_q  <= vic_line_valid_i;
      cls_q <= vic_shared_i | vic_owned_i;
    end
  end

  always_comb begin
    lower_valid = 1'b1;
    for (int w = 0; w < NUM_WAYS; w++)
      if (WAY_W'(w) < vic_way_o && !lv_q[w]) lower_valid = 1'b0;
  end

  p_valid_after_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vic_req_i |=> vic_valid_o);

  p_idle_after_no_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vic_req_i |=> !vic_valid_o);

  p_invalid_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vic_valid_o && !(&lv_q)) |-> (!lv_q[vic_way_o] && lower_valid));

  p_private_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vic_valid_o && (&lv_q) && !(&cls_q)) |-> !cls_q[vic_way_o]);

  p_access_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vic_req_i && acc_valid_i && acc_set_i == vic_set_i && (&vic_line_valid_i)
     && (vic_shared_i | vic_owned_i) == '0) |=> (vic_way_o != $past(acc_way_i)));
endmodule

bind lru_victim_sel lru_victim_sel_chk #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .acc_valid_i      (acc_valid_i),
  .acc_set_i        (acc_set_i),
  .acc_way_i        (acc_way_i),
  .vic_req_i        (vic_req_i),
  .vic_set_i        (vic_set_i),
  .vic_line_valid_i (vic_line_valid_i),
  .vic_shared_i     (vic_shared_i),
  .vic_owned_i      (vic_owned_i),
  .vic_valid_o      (vic_valid_o),
  .vic_way_o        (vic_way_o)
);

// File: tb/lru_victim_sel_test.sv
`timescale 1ns/1ps
module lru_victim_sel_test;
  localparam int NS = 16;
  localparam int NW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          acc_valid_i = 1'b0;
  logic [3:0]    acc_set_i = '0;
  logic [1:0]    acc_way_i = '0;
  logic          vic_req_i = 1'b0;
  logic [3:0]    vic_set_i = '0;
  logic [NW-1:0] vic_line_valid_i = '1;
  logic [NW-1:0] vic_shared_i = '0;
  logic [NW-1:0] vic_owned_i = '0;
  logic          vic_valid_o;
  logic [1:0]    vic_way_o;

  int checks = 0;
  int errors = 0;
  int tick   = 0;
  int stamp [NS][NW];
  logic [15:0] lfsr = 16'hace1;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  lru_victim_sel #(.NUM_SETS(NS), .NUM_WAYS(NW)) uut (.*);

  function automatic int model_victim(int s, logic [NW-1:0] lv, logic [NW-1:0] sh, logic [NW-1:0] ow);
    int best = -1;
    int bc = 0;
    for (int w = 0; w < NW; w++) if (!lv[w]) return w;
    for (int w = 0; w < NW; w++) begin
      int c = (sh[w] | ow[w]) ? 1 : 0;
      if (best < 0 || c < bc || (c == bc && stamp[s][w] < stamp[s][best])) begin
        best = w;
        bc = c;
      end
    end
    return best;
  endfunction

  function automatic logic [15:0] step(logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic touch_model(int s, int w);
    tick++;
    stamp[s][w] = tick;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_access(int s, int w);
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_set_i = 4'(s); acc_way_i = 2'(w);
    @(negedge clk_i);
    acc_valid_i = 1'b0;
    touch_model(s, w);
  endtask

  // request, optionally colliding with an access; checks valid and way
  task automatic do_req(int s, logic [NW-1:0] lv, logic [NW-1:0] sh, logic [NW-1:0] ow,
                        bit with_acc, int acc_s, int acc_w, string req);
    int exp;
    @(negedge clk_i);
    vic_req_i = 1'b1; vic_set_i = 4'(s);
    vic_line_valid_i = lv; vic_shared_i = sh; vic_owned_i = ow;
    if (with_acc) begin
      acc_valid_i = 1'b1; acc_set_i = 4'(acc_s); acc_way_i = 2'(acc_w);
      touch_model(acc_s, acc_w);
    end
    exp = model_victim(s, lv, sh, ow);
    @(negedge clk_i);
    vic_req_i = 1'b0; acc_valid_i = 1'b0;
    check({req, " valid R2"}, int'(vic_valid_o), 1);
    check(req, int'(vic_way_o), exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) stamp[s][w] = -w;
    repeat (3) @(negedge clk_i);
    check("R1 valid low in reset", int'(vic_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid low after reset", int'(vic_valid_o), 0);

    // R1: reset order puts the highest way oldest, in every set
    for (int s = 0; s < NS; s++) do_req(s, '1, '0, '0, 0, 0, 0, "R1");
    @(negedge clk_i);
    check("R2 valid drops", int'(vic_valid_o), 0);

    // R3: touch all ways in order; way 0 becomes oldest
    for (int w = 0; w < NW; w++) do_access(2, w);
    do_req(2, '1, '0, '0, 0, 0, 0, "R3");
    do_access(2, 0);
    do_req(2, '1, '0, '0, 0, 0, 0, "R3");

    // R8: heavy traffic to set 5 must not disturb set 6
    for (int i = 0; i < 8; i++) do_access(5, i % NW);
    do_req(6, '1, '0, '0, 0, 0, 0, "R8");

    // main sweep: history per set, then all shared/owned patterns
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < 6; i++) begin
        lfsr = step(lfsr);
        do_access(s, int'(lfsr[1:0]));
      end
      lfsr = step(lfsr);
      do_access((s + 1) % NS, int'(lfsr[3:2]));
      for (int p = 0; p < 256; p++) begin
        logic [NW-1:0] sh, ow, cls;
        string tag;
        sh = p[3:0]; ow = p[7:4]; cls = sh | ow;
        if (cls == '1)      tag = "R9";
        else if (cls == '0) tag = "R5";
        else                tag = "R4";
        do_req(s, '1, sh, ow, 0, 0, 0, tag);
        if (p % 32 == 31) begin
          lfsr = step(lfsr);
          do_access(s, int'(lfsr[1:0]));
        end
      end
      for (int v = 0; v < 15; v++) begin
        lfsr = step(lfsr);
        do_req(s, 4'(v), lfsr[3:0], lfsr[7:4], 0, 0, 0, "R6");
      end
    end

    // R7: same-set collision, access applied before the choice
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        do_req(s, '1, '0, '0, 1, s, w, "R7");
        lfsr = step(lfsr);
        do_req(s, '1, lfsr[3:0], '0, 1, s, int'(lfsr[5:4]), "R7");
      end
    // collision in different sets
    do_req(3, '1, '0, '0, 1, 4, 3, "R8");

    @(negedge clk_i);
    check("R2 valid idle", int'(vic_valid_o), 0);
    finish_run();
  end
endmodule